// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O DDR Synchronous SRAM

This block is a synchronous memory with separate read and write data ports. Addresses and commands arrive at single data rate. Data moves at double data rate. Every access transfers exactly two words, so one request per clock cycle is enough to keep both data ports busy. Reads and writes share one address bus and one read/write select. A request is taken only on a rising clock edge where the active-low load strobe is asserted. Several instances can share the select and address lines, each with its own load strobe, to build a deeper memory.

Each address names a two-word location. The first word of a burst belongs to the even word and the second to the odd word. Write data follows its request by one cycle, with a byte mask for each word. Read data comes back 1.5 cycles after the request, together with a valid flag and a pair of echo clocks that mark the two output words. A write and a read can be in progress in the same cycle because the two data ports never turn around.

Top module: `sio_ddr_sram`

## Requirements
- R1: After a rising edge with `rst_n` low, `rdata_vld`, `echo_clk` and `echo_clk_n` are all 0.
- R2: When `ld_n` is 1 at a rising edge, no request is taken. No read data appears, and data on `wdata` in the following cycle changes no stored word.
- R3: At a rising edge with `ld_n` = 0, `rw_sel` = 1 requests a read and `rw_sel` = 0 requests a write. A read request changes no stored word, even while `wdata` carries values with all lanes enabled.
- R4: For a write taken at rising edge T, the word on `wdata` at rising edge T+1 is stored in the even word of the addressed location. The word at the falling edge that follows is stored in the odd word.
- R5: `bw_n` is active low and is sampled together with each write word. Bit i enables data bits [9i+8:9i], cut off at the data width. A lane with `bw_n` = 1 keeps its old contents.
- R6: For a read taken at rising edge T, the even word is on `rdata` from the falling edge after T+1 until rising edge T+2, and the odd word from T+2 until the next falling edge. `rdata_vld` is 1 for exactly these two half-cycles.
- R7: `echo_clk_n` is 1 only while the even read word is driven. `echo_clk` is 1 only while the odd read word is driven. Both are 0 when no read data is out.
- R8: A read taken in the cycle right after a write to the same location returns the newly written lanes, merged with the old contents of the masked lanes.
- R9: One request can be taken on every rising edge. Back-to-back writes, back-to-back reads and alternating reads and writes each give the same results as the same requests spread out in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Commands use the rising edge; data uses both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Active-low load strobe for this bank |
| rw_sel | input | 1 | 1 = read, 0 = write; shared by all banks |
| addr | input | ADDR_W | Two-word location address |
| wdata | input | DATA_W | DDR write data |
| bw_n | input | BE_W | Active-low byte-lane write enables, one set per write word |
| rdata | output | DATA_W | DDR read data |
| rdata_vld | output | 1 | High while `rdata` carries a read word |
| echo_clk | output | 1 | Echo clock, high during the odd read word |
| echo_clk_n | output | 1 | Complementary echo clock, high during the even read word |

## Verification
The assertions assume that `ld_n` and `rw_sel` have known values at every rising edge once reset is released. They also assume that `wdata` and `bw_n` are stable around both edges of the cycle after a write request. The stimulus changes every input a quarter period after an edge, so each value is settled well before the edge that samples it. Every location is written with all lanes enabled before it is read, so each expected read word is fully defined.

// File: rtl/sio_sram_pkg.sv
// Package: shared constants and helpers for the separate-I/O DDR SRAM.
// Assumes byte lanes are nine bits wide, and narrower only in the last lane.
package sio_sram_pkg;

    localparam int LANE_W = 9;

    // Number of byte-enable lanes needed to cover a data word of width w.
    function automatic int lane_count(input int w);
        return (w + LANE_W - 1) / LANE_W;
    endfunction

endpackage

// File: rtl/sio_req_decode.sv
// Module: sio_req_decode
// Samples the load strobe, read/write select and address on the rising edge.
// Turns them into one-cycle read or write request flags, then delays the
// read request by one more cycle so the output stage can launch on the
// following falling edge.
// Assumes at most one request per cycle, which the single select line ensures.
module sio_req_decode #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              rd_stage,
    output logic [ADDR_W-1:0] rd_addr_s
);

    // Register the request that the load strobe qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req   <= 1'b0;
            wr_req   <= 1'b0;
            req_addr <= '0;
        end else begin
            rd_req   <= !ld_n && rw_sel;
            wr_req   <= !ld_n && !rw_sel;
            req_addr <= addr;
        end
    end

    // Second read stage: the output stage loads from it on the next falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stage  <= 1'b0;
            rd_addr_s <= '0;
        end else begin
            rd_stage  <= rd_req;
            rd_addr_s <= req_addr;
        end
    end

    // R2: a deasserted load strobe leaves both request flags clear.
    a_r2_ld_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> (!rd_req && !wr_req));

    // R6: every accepted read moves into the launch stage one cycle later.
    a_r6_rd_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_stage);

endmodule

// File: rtl/sio_wr_capture.sv
// Module: sio_wr_capture
// Collects the two DDR words of a write burst. The even word and its lane
// mask are taken on the rising edge after the request. The odd word and its
// mask are taken on the falling edge that follows. The lane enables are
// widened to a per-bit mask once, here.
// Assumes wr_req is a one-cycle flag from the request decoder.
module sio_wr_capture
    import sio_sram_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   bw_n,
    output logic              cm_en,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_d0,
    output logic [DATA_W-1:0] cm_m0,
    output logic [DATA_W-1:0] cm_d1,
    output logic [DATA_W-1:0] cm_m1
);

    logic [DATA_W-1:0] bit_we;

    // Widen each active-low lane enable to a per-bit write mask.
    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
        assign bit_we[j] = ~bw_n[j / LANE_W];
    end

    // Capture the even word, its mask and the address on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_en   <= 1'b0;
            cm_addr <= '0;
            cm_d0   <= '0;
            cm_m0   <= '0;
        end else begin
            cm_en <= wr_req;
            if (wr_req) begin
                cm_addr <= req_addr;
                cm_d0   <= wdata;
                cm_m0   <= bit_we;
            end
        end
    end

    // Capture the odd word and its mask on the falling edge of the same cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            cm_d1 <= '0;
            cm_m1 <= '0;
        end else if (cm_en) begin
            cm_d1 <= wdata;
            cm_m1 <= bit_we;
        end
    end

    // R4: a write request leads to a commit slot for the same address.
    a_r4_commit_slot: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (cm_en && (cm_addr == $past(req_addr))));

    // R3: no commit slot opens without a write request.
    a_r3_no_stray_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !cm_en);

endmodule

// File: rtl/sio_pair_store.sv
// Module: sio_pair_store
// Storage split into an even-word bank and an odd-word bank. Both words of a
// captured burst are written on one rising edge, merged bit by bit with the
// stored value. Reads are combinational from the staged read address.
// Assumes the masks are already per-bit and active high.
module sio_pair_store #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              cm_en,
    input  logic [ADDR_W-1:0] cm_addr,
    input  logic [DATA_W-1:0] cm_d0,
    input  logic [DATA_W-1:0] cm_m0,
    input  logic [DATA_W-1:0] cm_d1,
    input  logic [DATA_W-1:0] cm_m1,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_even,
    output logic [DATA_W-1:0] rd_odd
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] rd_word [2];

    for (genvar k = 0; k < 2; k++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] wm;

        assign wd = (k == 0) ? cm_d0 : cm_d1;
        assign wm = (k == 0) ? cm_m0 : cm_m1;

        // Merge the enabled bits of the burst word into its bank.
        always_ff @(posedge clk) begin
            if (cm_en) begin
                mem[cm_addr] <= (mem[cm_addr] & ~wm) | (wd & wm);
            end
        end

        assign rd_word[k] = mem[rd_addr];
    end

    assign rd_even = rd_word[0];
    assign rd_odd  = rd_word[1];

endmodule

// File: rtl/sio_rd_launch.sv
// Module: sio_rd_launch
// Launches read data on the falling edge. Both words are registered on the
// same falling edge, and the clock level selects which word is driven: the
// even word while the clock is low, the odd word while it is high. The echo
// clock pair is formed from the same clock level, gated by the valid flag.
// Assumes rd_stage is a one-cycle flag that changes on rising edges only.
module sio_rd_launch #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stage,
    input  logic [DATA_W-1:0] rd_even,
    input  logic [DATA_W-1:0] rd_odd,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld,
    output logic              echo_clk,
    output logic              echo_clk_n
);

    logic              vld_q;
    logic [DATA_W-1:0] w0_q;
    logic [DATA_W-1:0] w1_q;

    // Load both burst words and the valid flag on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            w0_q  <= '0;
            w1_q  <= '0;
        end else begin
            vld_q <= rd_stage;
            if (rd_stage) begin
                w0_q <= rd_even;
                w1_q <= rd_odd;
            end
        end
    end

    // Drive the word that belongs to the current half-cycle, plus the echoes.
    always_comb begin
        rdata      = clk ? w1_q : w0_q;
        rdata_vld  = vld_q;
        echo_clk   = vld_q & clk;
        echo_clk_n = vld_q & ~clk;
    end

    // R6: the output window matches the staged read of the cycle before.
    a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stage |-> vld_q);

    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stage |-> !vld_q);

    // R7: the even-word echo stays low when no read was staged.
    a_r7_echo_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stage |-> !echo_clk_n);

endmodule

// File: rtl/sio_ddr_sram.sv
// Module: sio_ddr_sram (top)
// Burst-of-two memory with a single-rate command/address bus and separate
// DDR write and read data ports. Request decoding, write capture, storage
// and read launch are separate submodules.
// Assumes the caller keeps the inputs stable around the edges that sample them.
module sio_ddr_sram
    import sio_sram_pkg::*;
#(
    parameter  int DATA_W = 36,
    parameter  int ADDR_W = 8,
    localparam int BE_W   = lane_count(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   bw_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld,
    output logic              echo_clk,
    output logic              echo_clk_n
);

    logic              rd_req;
    logic              wr_req;
    logic [ADDR_W-1:0] req_addr;
    logic              rd_stage;
    logic [ADDR_W-1:0] rd_addr_s;
    logic              cm_en;
    logic [ADDR_W-1:0] cm_addr;
    logic [DATA_W-1:0] cm_d0;
    logic [DATA_W-1:0] cm_m0;
    logic [DATA_W-1:0] cm_d1;
    logic [DATA_W-1:0] cm_m1;
    logic [DATA_W-1:0] rd_even;
    logic [DATA_W-1:0] rd_odd;

    sio_req_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .rw_sel    (rw_sel),
        .addr      (addr),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .req_addr  (req_addr),
        .rd_stage  (rd_stage),
        .rd_addr_s (rd_addr_s)
    );

    sio_wr_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_wcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .req_addr (req_addr),
        .wdata    (wdata),
        .bw_n     (bw_n),
        .cm_en    (cm_en),
        .cm_addr  (cm_addr),
        .cm_d0    (cm_d0),
        .cm_m0    (cm_m0),
        .cm_d1    (cm_d1),
        .cm_m1    (cm_m1)
    );

    sio_pair_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .cm_en   (cm_en),
        .cm_addr (cm_addr),
        .cm_d0   (cm_d0),
        .cm_m0   (cm_m0),
        .cm_d1   (cm_d1),
        .cm_m1   (cm_m1),
        .rd_addr (rd_addr_s),
        .rd_even (rd_even),
        .rd_odd  (rd_odd)
    );

    sio_rd_launch #(.DATA_W(DATA_W)) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stage   (rd_stage),
        .rd_even    (rd_even),
        .rd_odd     (rd_odd),
        .rdata      (rdata),
        .rdata_vld  (rdata_vld),
        .echo_clk   (echo_clk),
        .echo_clk_n (echo_clk_n)
    );

    // R9: the read and write paths never hold a request in the same cycle.
    a_r9_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req}));

endmodule

// File: tb/sio_ddr_sram_tb.sv
module sio_ddr_sram_tb;

    localparam int CLK_P = 10;
    localparam int W     = 36;
    localparam int AW    = 8;
    localparam int BE    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld_n;
    logic          rw_sel;
    logic [AW-1:0] addr;
    logic [W-1:0]  wdata;
    logic [BE-1:0] bw_n;
    logic [W-1:0]  rdata;
    logic          rdata_vld;
    logic          echo_clk;
    logic          echo_clk_n;

    sio_ddr_sram #(.DATA_W(W), .ADDR_W(AW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_n       (ld_n),
        .rw_sel     (rw_sel),
        .addr       (addr),
        .wdata      (wdata),
        .bw_n       (bw_n),
        .rdata      (rdata),
        .rdata_vld  (rdata_vld),
        .echo_clk   (echo_clk),
        .echo_clk_n (echo_clk_n)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic [W-1:0] w0;
        logic [W-1:0] w1;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [W-1:0]  m_even [DEPTH];
    logic [W-1:0]  m_odd  [DEPTH];
    logic [W-1:0]  p_d0 = '0, p_d1 = '0;
    logic [BE-1:0] p_m0 = '1, p_m1 = '1;
    int  n_chk  = 0;
    int  n_fail = 0;
    bit  mon_en = 1'b0;
    bit  done   = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [W-1:0] merge(input logic [W-1:0] o, input logic [W-1:0] n, input logic [BE-1:0] m);
        logic [W-1:0] r;
        for (int j = 0; j < W; j++) r[j] = m[j / 9] ? o[j] : n[j];
        return r;
    endfunction

    function automatic logic [W-1:0] pat(input int a, input int k);
        return {8'(a), 8'hC3 ^ 8'(k), 20'(a * 37 + k * 1021 + 5)};
    endfunction

    // Driver: one request per call; the scoreboard queue gets the expected reads.
    task automatic step(input bit en, input bit rd, input int a,
                        input logic [W-1:0] d0, input logic [W-1:0] d1,
                        input logic [BE-1:0] m0, input logic [BE-1:0] m1, input string tag);
        ld_n   = !en;
        rw_sel = rd;
        addr   = AW'(a);
        wdata  = p_d0;
        bw_n   = p_m0;
        if (en && rd) exp_q.push_back('{cyc + 2, m_even[a], m_odd[a], tag});
        if (en && !rd) begin
            m_even[a] = merge(m_even[a], d0, m0);
            m_odd[a]  = merge(m_odd[a], d1, m1);
        end
        @(posedge clk);
        #(CLK_P/4);
        wdata = p_d1;
        bw_n  = p_m1;
        p_d0 = d0; p_d1 = d1; p_m0 = m0; p_m1 = m1;
        @(negedge clk);
        #(CLK_P/4);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 0, '0, '0, '1, '1, "");
    endtask

    // Monitor: pops expected bursts and compares both halves and the echoes.
    initial begin
        bit           w1_pend = 1'b0;
        logic [W-1:0] w1_val  = '0;
        string        w1_tag  = "";
        exp_t         it;
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (mon_en) begin
                if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                    it = exp_q.pop_front();
                    chk(rdata_vld && !echo_clk && echo_clk_n && (rdata === it.w0),
                        {it.tag, " R6 R7 even word"}, rdata, it.w0);
                    w1_pend = 1'b1; w1_val = it.w1; w1_tag = it.tag;
                end else begin
                    chk(!rdata_vld && !echo_clk && !echo_clk_n, "R7 R2 idle low phase",
                        W'({rdata_vld, echo_clk, echo_clk_n}), '0);
                end
            end
            @(posedge clk);
            #(CLK_P/4);
            if (mon_en) begin
                if (w1_pend) begin
                    chk(rdata_vld && echo_clk && !echo_clk_n && (rdata === w1_val),
                        {w1_tag, " R6 R7 odd word"}, rdata, w1_val);
                    w1_pend = 1'b0;
                end else begin
                    chk(!rdata_vld && !echo_clk && !echo_clk_n, "R7 R2 idle high phase",
                        W'({rdata_vld, echo_clk, echo_clk_n}), '0);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ld_n = 1'b1; rw_sel = 1'b1; addr = '0; wdata = '0; bw_n = '1;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        chk(!rdata_vld && !echo_clk && !echo_clk_n, "R1 reset high phase",
            W'({rdata_vld, echo_clk, echo_clk_n}), '0);
        @(negedge clk);
        #(CLK_P/4);
        chk(!rdata_vld && !echo_clk && !echo_clk_n, "R1 reset low phase",
            W'({rdata_vld, echo_clk, echo_clk_n}), '0);
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // R4 R9: fill every location with back-to-back full-lane writes.
        for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, a, pat(a, 0), pat(a, 1), '0, '0, "");
        idle(2);

        // R4 R9: back-to-back reads of scattered locations.
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1, i * 17, pat(i, 9), pat(i, 10), '0, '0, "R4");
        idle(3);

        // R5: partial lane masks, and a write with every lane disabled.
        step(1'b1, 1'b0, 20, pat(200, 1), pat(200, 2), BE'(4'b0101), BE'(4'b1010), "");
        idle(1);
        step(1'b1, 1'b1, 20, '0, '0, '1, '1, "R5");
        step(1'b1, 1'b0, 21, pat(201, 1), pat(201, 2), '1, '1, "");
        idle(1);
        step(1'b1, 1'b1, 21, '0, '0, '1, '1, "R5");
        idle(3);

        // R8: a read right after a write to the same location.
        step(1'b1, 1'b0, 30, pat(300, 5), pat(300, 6), BE'(4'b0011), BE'(4'b1100), "");
        step(1'b1, 1'b1, 30, '0, '0, '1, '1, "R8");
        step(1'b1, 1'b0, 31, pat(310, 5), pat(310, 6), '0, '0, "");
        step(1'b1, 1'b1, 31, '0, '0, '1, '1, "R8");
        idle(3);

        // R2: strobe high with write data present, then with a read select.
        step(1'b0, 1'b0, 40, pat(400, 7), pat(400, 8), '0, '0, "");
        step(1'b0, 1'b1, 41, pat(410, 7), pat(410, 8), '0, '0, "");
        idle(2);
        step(1'b1, 1'b1, 40, '0, '0, '1, '1, "R2");
        idle(3);

        // R3: reads while the write bus carries enabled data leave contents alone.
        step(1'b1, 1'b1, 50, pat(500, 1), pat(500, 2), '0, '0, "R3");
        step(1'b1, 1'b1, 50, pat(501, 1), pat(501, 2), '0, '0, "R3");
        step(1'b1, 1'b1, 50, '0, '0, '1, '1, "R3");
        idle(3);

        // R9: alternating writes and reads every cycle.
        for (int i = 0; i < 20; i++) begin
            if (i % 2 == 0)
                step(1'b1, 1'b0, 100 + i / 2, pat(600 + i, 3), pat(600 + i, 4), BE'(i), BE'(15 - i % 16), "");
            else
                step(1'b1, 1'b1, 100 + i / 2, '0, '0, '1, '1, "R9");
        end
        idle(4);

        chk(exp_q.size() == 0, "R6 all reads returned", W'(exp_q.size()), '0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule